// File: doc/BRIEF.md
# Filtered Edge Interrupt Front-End

This block conditions a set of interrupt-capable input lines, up to 24 by default, before they reach a parent interrupt controller. Each incoming line first passes through a two-stage synchronizer. It then goes through a per-line noise filter, which accepts a new level only after that level has held for a programmed number of clock cycles. A per-line output stage then decides what the parent sees.

Configuration arrives as flat per-line bit vectors and one shared period value. Each line has an enable bit, a both-edge mode bit and a filter-enable bit. The 8-bit filter period applies to all lines, and software normally programs it to 0xFF. In level mode the parent sees a level: the filtered level when the filter is on, the synchronized raw level when it is off. In both-edge mode, every accepted transition becomes a one-cycle low pulse. The parent should therefore be set to falling-edge sensitivity. Both-edge mode relies on the filter, so with the filter off a line in that mode produces no events.

Each line's filter is a two-state machine:

- **STEADY**: the accepted level matches the synchronized input. When the input differs, the machine latches the current period. It then either accepts at once (period 0 or 1) or moves to QUALIFY.
- **QUALIFY**: the machine counts consecutive samples at the new level.
  - If the input returns to the accepted level, it aborts back to STEADY.
  - When the count reaches the latched period, it accepts the new level and returns to STEADY.

The output stage selects one of five modes from the configuration: OFF_LOW, OFF_HIGH, RAW, FILTERED and EDGE.

Top module: `irq_edge_frontend`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every bit of `irq_out` is 0, and every filter treats 0 as its accepted level.
- R2: For an enabled line with mode bit 0 and filter bit 0, `irq_out` equals that line's input delayed by exactly three clock edges (two synchronizer stages plus one output register).
- R3: With the filter bit at 1, a new synchronized level is accepted only after P consecutive samples at that level, where P is the period (P of 0 or 1 means one sample). In level mode, `irq_out` changes 3+P clock edges after the input changes (4 edges when P is 0).
- R4: A synchronized excursion shorter than P samples is discarded. The accepted level and the output stay unchanged, and the next excursion starts counting from one.
- R5: One period value serves every line. A line latches the period when it starts qualifying a new level, so a change to the period during qualification affects only that line's next qualification.
- R6: An enabled line with mode bit 1 and filter bit 1 holds `irq_out` at 1. Each accepted transition, rising or falling, drives it to 0 for exactly one cycle, 3+P edges after the input change.
- R7: An enabled line with mode bit 1 and filter bit 0 holds `irq_out` at 1 whatever its input does.
- R8: A line with enable bit 0 holds `irq_out` at its inactive level: 0 with mode bit 0, 1 with mode bit 1. Its filter keeps tracking the input, so one edge after re-enabling in filtered level mode the output shows the already accepted level.
- R9: The configuration bits at position i, and input bit i, affect only `irq_out[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | LINES | Asynchronous interrupt input lines |
| irq_enable | input | LINES | Per-line output enable (1 = pass) |
| irq_both_edge | input | LINES | Per-line mode (1 = both-edge pulses, 0 = level) |
| irq_filter_en | input | LINES | Per-line noise filter enable |
| filter_period | input | CNT_W | Shared filter period in clock cycles |
| irq_out | output | LINES | Conditioned outputs to the parent controller |

## Verification
The hardest situation to reach is a period change that arrives while a line is part-way through QUALIFY. In that case the old and new periods must produce different acceptance times on the same line. A directed case starts a long qualification, shortens the period mid-count, and checks that the first acceptance keeps the old timing while the next one uses the new value. A second hard case is a glitch that is exactly one sample short of the period. Directed pulses of P-1 and P samples cover both sides of that boundary. Random traffic with frequent configuration changes then checks every line every cycle against a bench model, which also exercises mode switches in mid-qualification.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    // Per-line noise filter states
    typedef enum logic {
        FLT_STEADY,
        FLT_QUALIFY
    } flt_state_e;

    // Output stage selection
    typedef enum logic [2:0] {
        SEL_OFF_LOW,
        SEL_OFF_HIGH,
        SEL_RAW,
        SEL_FILTERED,
        SEL_EDGE
    } out_sel_e;

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < STAGES; k++) chain[k] <= '0;
                end else begin
                    chain[0] <= d;
                    for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/irqfe_filter.sv
module irqfe_filter
    import irqfe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic [CNT_W-1:0] period,
    output logic             level,
    output logic             flip
);

    localparam logic [CNT_W:0] ONE_W = (CNT_W+1)'(1);

    flt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic             acc_q, acc_d;
    logic             flip_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + ONE_W;

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lim_d = lim_q;
        acc_d = acc_q;
        unique case (st_q)
            FLT_STEADY: begin
                if (smp != acc_q) begin
                    lim_d = period;
                    if (period <= CNT_W'(1)) begin
                        acc_d = smp;
                    end else begin
                        st_d  = FLT_QUALIFY;
                        cnt_d = CNT_W'(1);
                    end
                end
            end
            FLT_QUALIFY: begin
                if (smp == acc_q) begin
                    st_d = FLT_STEADY;
                end else if (cnt_inc >= {1'b0, lim_q}) begin
                    acc_d = smp;
                    st_d  = FLT_STEADY;
                end else begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            default: st_d = FLT_STEADY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FLT_STEADY;
            cnt_q  <= '0;
            lim_q  <= '0;
            acc_q  <= 1'b0;
            flip_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            lim_q  <= lim_d;
            acc_q  <= acc_d;
            flip_q <= (acc_d != acc_q);
        end
    end

    // Outputs
    always_comb begin
        level = acc_q;
        flip  = flip_q;
    end

    // R3: the accepted level only ever takes a value the input presented
    a_r3_accept_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q != $past(acc_q)) |-> (acc_q == $past(smp)));

    // R4: qualification count stays under its latched limit
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLT_QUALIFY) |-> (cnt_q < lim_q && lim_q > CNT_W'(1)));

    // R4: an excursion that ends early leaves the accepted level untouched
    a_r4_abort_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLT_QUALIFY && smp == acc_q) |=> (st_q == FLT_STEADY && acc_q == $past(acc_q)));

    // R6: a flip marker appears only after a level change
    a_r6_flip_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLT_STEADY && smp == acc_q) |=> !flip_q);

endmodule

// File: rtl/irqfe_out.sv
module irqfe_out
    import irqfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic both,
    input  logic flt_en,
    input  logic raw,
    input  logic level,
    input  logic flip,
    output logic out
);

    out_sel_e sel;
    logic     out_q;
    logic     primed_q;

    // Mode selection
    always_comb begin
        if (!en)          sel = both ? SEL_OFF_HIGH : SEL_OFF_LOW;
        else if (both)    sel = flt_en ? SEL_EDGE : SEL_OFF_HIGH;
        else if (flt_en)  sel = SEL_FILTERED;
        else              sel = SEL_RAW;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            unique case (sel)
                SEL_OFF_LOW:  out_q <= 1'b0;
                SEL_OFF_HIGH: out_q <= 1'b1;
                SEL_RAW:      out_q <= raw;
                SEL_FILTERED: out_q <= level;
                SEL_EDGE:     out_q <= ~flip;
                default:      out_q <= 1'b0;
            endcase
        end
    end

    assign out = out_q;

    // R8: masked line sits at the inactive level of its mode
    a_r8_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(!en)) |-> (out_q == $past(both)));

    // R7: both-edge without filter never pulses
    a_r7_no_unfiltered_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(en && both && !flt_en)) |-> out_q);

    // R2: unfiltered level mode follows the synchronized line
    a_r2_raw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(en && !both && !flt_en)) |-> (out_q == $past(raw)));

    // R6: pulse low exactly when the filter flagged a transition
    a_r6_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(en && both && flt_en)) |-> (out_q == !$past(flip)));

endmodule

// File: rtl/irq_edge_frontend.sv
module irq_edge_frontend #(
    parameter int LINES       = 24,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] irq_enable,
    input  logic [LINES-1:0] irq_both_edge,
    input  logic [LINES-1:0] irq_filter_en,
    input  logic [CNT_W-1:0] filter_period,
    output logic [LINES-1:0] irq_out
);

    localparam int SYNC_W = LINES;

    logic [SYNC_W-1:0] synced;
    logic [LINES-1:0]  flt_level;
    logic [LINES-1:0]  flt_flip;

    irqfe_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (synced)
    );

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            irqfe_filter #(
                .CNT_W (CNT_W)
            ) u_filter (
                .clk    (clk),
                .rst_n  (rst_n),
                .smp    (synced[i]),
                .period (filter_period),
                .level  (flt_level[i]),
                .flip   (flt_flip[i])
            );

            irqfe_out u_out (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (irq_enable[i]),
                .both   (irq_both_edge[i]),
                .flt_en (irq_filter_en[i]),
                .raw    (synced[i]),
                .level  (flt_level[i]),
                .flip   (flt_flip[i]),
                .out    (irq_out[i])
            );
        end
    endgenerate

endmodule

// File: tb/test_irq_edge_frontend.sv
module test_irq_edge_frontend;

    localparam int N  = 24;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic [N-1:0]  irq_enable = '0;
    logic [N-1:0]  irq_both_edge = '0;
    logic [N-1:0]  irq_filter_en = '0;
    logic [CW-1:0] filter_period = 8'hFF;
    logic [N-1:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit model_on = 1'b0;

    irq_edge_frontend #(.LINES(N), .CNT_W(CW), .SYNC_STAGES(2)) i_irq_edge_frontend (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .irq_enable    (irq_enable),
        .irq_both_edge (irq_both_edge),
        .irq_filter_en (irq_filter_en),
        .filter_period (filter_period),
        .irq_out       (irq_out)
    );

    always #5 clk = ~clk;

    // Reference model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_acc, m_flip, m_out, m_qual;
    int           m_cnt [N];
    int           m_lim [N];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_acc = '0; m_flip = '0; m_out = '0; m_qual = '0;
            for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_lim[i] = 0; end
        end else begin
            for (int i = 0; i < N; i++) begin
                logic nacc;
                if (!irq_enable[i])        m_out[i] = irq_both_edge[i];
                else if (irq_both_edge[i]) m_out[i] = irq_filter_en[i] ? !m_flip[i] : 1'b1;
                else if (irq_filter_en[i]) m_out[i] = m_acc[i];
                else                       m_out[i] = m_s2[i];
                nacc = m_acc[i];
                if (!m_qual[i]) begin
                    if (m_s2[i] != m_acc[i]) begin
                        m_lim[i] = int'(filter_period);
                        if (m_lim[i] <= 1) nacc = m_s2[i];
                        else begin m_qual[i] = 1'b1; m_cnt[i] = 1; end
                    end
                end else begin
                    if (m_s2[i] == m_acc[i]) m_qual[i] = 1'b0;
                    else if (m_cnt[i] + 1 >= m_lim[i]) begin nacc = m_s2[i]; m_qual[i] = 1'b0; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
                m_flip[i] = (nacc != m_acc[i]);
                m_acc[i]  = nacc;
            end
            m_s2 = m_s1;
            m_s1 = line_in;
        end
    end

    function automatic string tag_for(int i);
        if (!irq_enable[i])        return "R8";
        if (irq_both_edge[i])      return irq_filter_en[i] ? "R6" : "R7";
        if (irq_filter_en[i])      return "R3";
        return "R2";
    endfunction

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            for (int i = 0; i < N; i++) begin
                checks++;
                if (irq_out[i] !== m_out[i]) begin
                    failures++;
                    $display("FAIL %s/R9 line %0d: actual=%0b expected=%0b", tag_for(i), i, irq_out[i], m_out[i]);
                end
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line_in = '0;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", |irq_out, 1'b0);
        tick(1);
        check("R1", |irq_out, 1'b0);
        model_on = 1'b1;

        // R2: raw level latency of three edges
        irq_enable = '1; irq_both_edge = '0; irq_filter_en = '0;
        tick(4);
        line_in[0] = 1'b1;
        tick(2); check("R2", irq_out[0], 1'b0);
        tick(1); check("R2", irq_out[0], 1'b1);

        // R3: filtered latency 3+P with P=4
        do_reset();
        irq_filter_en = '1; filter_period = 8'd4;
        tick(2);
        line_in[1] = 1'b1;
        tick(6); check("R3", irq_out[1], 1'b0);
        tick(1); check("R3", irq_out[1], 1'b1);

        // R3: period 0 behaves as one sample
        do_reset();
        filter_period = 8'd0;
        tick(2);
        line_in[1] = 1'b1;
        tick(3); check("R3", irq_out[1], 1'b0);
        tick(1); check("R3", irq_out[1], 1'b1);

        // R4: glitch one sample short is dropped, full-length pulse accepted
        do_reset();
        filter_period = 8'd4;
        tick(2);
        line_in[2] = 1'b1; tick(3); line_in[2] = 1'b0;
        for (int k = 0; k < 10; k++) begin tick(1); check("R4", irq_out[2], 1'b0); end
        line_in[2] = 1'b1; tick(4); line_in[2] = 1'b0;
        tick(3); check("R4", irq_out[2], 1'b1);

        // R6: both-edge pulse, rising and falling, P=2
        do_reset();
        irq_both_edge = '1; filter_period = 8'd2;
        tick(3);
        check("R6", irq_out[3], 1'b1);
        line_in[3] = 1'b1;
        tick(4); check("R6", irq_out[3], 1'b1);
        tick(1); check("R6", irq_out[3], 1'b0);
        tick(1); check("R6", irq_out[3], 1'b1);
        line_in[3] = 1'b0;
        tick(5); check("R6", irq_out[3], 1'b0);
        tick(1); check("R6", irq_out[3], 1'b1);

        // R7: both-edge with filter off never pulses
        do_reset();
        irq_both_edge = '1; irq_filter_en = '0;
        tick(2);
        for (int k = 0; k < 12; k++) begin
            line_in[4] = ~line_in[4];
            tick(1); check("R7", irq_out[4], 1'b1);
        end

        // R8: masked levels, and filter tracks while masked
        do_reset();
        irq_enable = '0; irq_both_edge = '0; irq_filter_en = '1; filter_period = 8'd2;
        irq_both_edge[6] = 1'b1;
        line_in[5] = 1'b1; line_in[6] = 1'b1;
        tick(10);
        check("R8", irq_out[5], 1'b0);
        check("R8", irq_out[6], 1'b1);
        irq_enable[5] = 1'b1;
        tick(1); check("R8", irq_out[5], 1'b1);

        // R5: period latched at qualification start
        do_reset();
        irq_enable = '1; irq_both_edge = '0; irq_filter_en = '1; filter_period = 8'd6;
        tick(2);
        line_in[7] = 1'b1; line_in[8] = 1'b1;
        tick(4);
        filter_period = 8'd2;
        tick(4); check("R5", irq_out[7], 1'b0);
        tick(1); check("R5", irq_out[7], 1'b1);
        check("R5", irq_out[8], 1'b1);
        line_in[7] = 1'b0;
        tick(4); check("R5", irq_out[7], 1'b1);
        tick(1); check("R5", irq_out[7], 1'b0);

        // R9 and all modes: random traffic against the model
        do_reset();
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if (cyc % 97 == 0) begin
                irq_enable    = N'($urandom());
                irq_both_edge = N'($urandom());
                irq_filter_en = N'($urandom());
                filter_period = ($urandom_range(0, 15) == 0) ? 8'hFF : CW'($urandom_range(0, 7));
            end
            for (int i = 0; i < N; i++)
                if ($urandom_range(0, 5) == 0) line_in[i] = ~line_in[i];
            tick(1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule